// File: doc/BRIEF.md
# Four-Strobe Serial Word Loader

This block is the digital front end of a 12-bit converter with a serial input. A serial data pin feeds a shift register, most significant bit first. Four strobe pins act together as one shift clock: three shift on a rising edge and one shifts on a falling edge. Each strobe is honoured only while the other three sit in their quiet states. The bit pushed out of the top of the register appears on a serial output, so several loaders can be chained.

Two active-low transfer pins, both held low at once, copy the shift register into the output word that drives the converter. An active-low zero pin forces that word to all zeros. Every pin is asynchronous to the fast system clock. Each pin passes through a two-stage synchroniser, and the shift clock is found by detecting edges on the synchronised strobes.

Top module: `serial_dac_loader`

## Requirements
- R1: After synchronous reset, `dac_word` is 0 and `ser_out` is 0. The shift register is also 0, so a transfer straight after reset yields 0.
- R2: Each shift moves the register up by one place and takes `ser_in` into bit 0. After twelve shifts, the first bit shifted in sits in bit 11 and the last sits in bit 0.
- R3: A rising edge on `strobe_a`, `strobe_b` or `strobe_d` shifts once, provided `strobe_c` is high and the other two of those three are low.
- R4: A falling edge on `strobe_c` shifts once, provided `strobe_a`, `strobe_b` and `strobe_d` are all low.
- R5: Shifting follows the rising edges of the level (`strobe_a` OR `strobe_b` OR `strobe_d` OR NOT `strobe_c`). A strobe edge that arrives while that level is already high does not shift. Neither does any falling edge of that level. In both cases the register and `ser_out` are left unchanged.
- R6: While `xfer_a_n` and `xfer_b_n` are both low and `zero_n` is high, `dac_word` follows the shift register. If only one of the two is low, nothing is transferred.
- R7: While `zero_n` is low, `dac_word` is 0. This holds whatever the strobes and transfer pins do, and zero wins over a transfer in the same cycle.
- R8: On every shift, `ser_out` takes the bit that was in position 11 just before the shift. After a new 12-bit word has shifted in, the previous word has come out on `ser_out` in order.
- R9: A transfer in the same cycle as a shift captures the register value after that shift.
- R10: When no transfer and no zero are active, `dac_word` holds its value, however many shifts take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| strobe_a | input | 1 | strobe, shifts on rising edge |
| strobe_b | input | 1 | strobe, shifts on rising edge |
| strobe_c | input | 1 | strobe, shifts on falling edge, quiet state high |
| strobe_d | input | 1 | strobe, shifts on rising edge |
| ser_in | input | 1 | serial data, MSB first |
| xfer_a_n | input | 1 | first active-low transfer enable |
| xfer_b_n | input | 1 | second active-low transfer enable |
| zero_n | input | 1 | active-low force of the output word to zero |
| ser_out | output | 1 | bit shifted out of the register top |
| dac_word | output | WORD_W | word held for the converter |

## Verification
The assertions assume that every pin stays in its quiet state during reset: strobe_c high, the other strobes low, and both transfer pins and zero_n high. Otherwise the synchroniser would release a false edge when reset ends. They also assume that `ser_in` settles before the strobe edge that samples it, since data and strobes take the same synchroniser delay. The stimulus changes pins only on falling clock edges. It keeps reset asserted for several cycles with all pins quiet. It sets the data bit two cycles before each strobe edge and leaves several cycles between edges, so every edge reaches the register on its own.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int unsigned WORD_W_DEF     = 12;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } strobe_t;

    typedef struct packed {
        logic    ser;
        logic    zero_n;
        logic    xfer_b_n;
        logic    xfer_a_n;
        strobe_t stb;
    } pins_t;

    localparam pins_t PINS_IDLE = pins_t'{
        ser: 1'b0, zero_n: 1'b1, xfer_b_n: 1'b1, xfer_a_n: 1'b1,
        stb: strobe_t'{a: 1'b0, b: 1'b0, c: 1'b1, d: 1'b0}
    };

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_CLEAR = 2'd2
    } reg_op_e;

    // One shift clock made from the four strobes; c counts when low.
    function automatic logic shift_level(strobe_t s);
        return s.a | s.b | s.d | ~s.c;
    endfunction

    // Zero beats transfer; transfer needs both enables low.
    function automatic reg_op_e reg_op(pins_t p);
        if (!p.zero_n)
            return OP_CLEAR;
        else if (!p.xfer_a_n && !p.xfer_b_n)
            return OP_LOAD;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= IDLE;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/sdl_rise_detect.sv
module sdl_rise_detect #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= IDLE;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         ser_bit,
    output logic [W-1:0] word_q,
    output logic [W-1:0] word_nxt,
    output logic         ser_out
);
    always_comb begin
        word_nxt = word_q;
        if (shift_en) word_nxt = {word_q[W-2:0], ser_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            ser_out <= 1'b0;
        end else begin
            word_q <= word_nxt;
            if (shift_en) ser_out <= word_q[W-1];
        end
    end
endmodule

// File: rtl/sdl_dacreg.sv
module sdl_dacreg
    import sdl_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_op_e      op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] dac_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: dac_q <= '0;
                OP_LOAD:  dac_q <= load_val;
                default:  dac_q <= dac_q;
            endcase
        end
    end
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
    import sdl_pkg::*;
#(
    parameter int unsigned WORD_W     = WORD_W_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              strobe_c,
    input  logic              strobe_d,
    input  logic              ser_in,
    input  logic              xfer_a_n,
    input  logic              xfer_b_n,
    input  logic              zero_n,
    output logic              ser_out,
    output logic [WORD_W-1:0] dac_word
);
    localparam int unsigned PIN_W = $bits(pins_t);

    pins_t             pins_raw;
    pins_t             pins_s;
    logic              shift_lvl;
    logic              shift_pulse;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] shreg_nxt;
    reg_op_e           op;
    logic              zero_s;
    logic              xa_s;
    logic              xb_s;

    assign pins_raw = {ser_in, zero_n, xfer_b_n, xfer_a_n,
                       strobe_a, strobe_b, strobe_c, strobe_d};

    sdl_sync #(
        .W     (PIN_W),
        .DEPTH (SYNC_DEPTH),
        .IDLE  (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign shift_lvl = shift_level(pins_s.stb);

    sdl_rise_detect #(
        .IDLE (1'b0)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (shift_lvl),
        .rise  (shift_pulse)
    );

    sdl_shifter #(
        .W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_pulse),
        .ser_bit  (pins_s.ser),
        .word_q   (shreg_q),
        .word_nxt (shreg_nxt),
        .ser_out  (ser_out)
    );

    assign op     = reg_op(pins_s);
    assign zero_s = pins_s.zero_n;
    assign xa_s   = pins_s.xfer_a_n;
    assign xb_s   = pins_s.xfer_b_n;

    // Transfer takes the post-shift value so a same-cycle shift is kept.
    sdl_dacreg #(
        .W (WORD_W)
    ) u_dac (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (shreg_nxt),
        .dac_q    (dac_word)
    );
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         shift_pulse,
    input logic         zero_s,
    input logic         xa_s,
    input logic         xb_s,
    input logic [W-1:0] shreg_q,
    input logic         ser_out,
    input logic [W-1:0] dac_word
);
    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !zero_s |=> dac_word == '0);

    // R6
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_s && !xa_s && !xb_s) |=> dac_word == shreg_q);

    // R10
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_s && (xa_s || xb_s)) |=> $stable(dac_word));

    // R5
    no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_pulse |=> ($stable(shreg_q) && $stable(ser_out)));

    // R2 R8
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> (shreg_q[W-1:1] == $past(shreg_q[W-2:0])
                         && ser_out == $past(shreg_q[W-1])));
endmodule

bind serial_dac_loader sdl_chk #(.W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .shift_pulse (shift_pulse),
    .zero_s      (zero_s),
    .xa_s        (xa_s),
    .xb_s        (xb_s),
    .shreg_q     (shreg_q),
    .ser_out     (ser_out),
    .dac_word    (dac_word)
);

// File: tb/tb_serial_dac_loader.sv
module tb_serial_dac_loader;
    localparam int CLK_P = 10;
    localparam int W     = 12;

    typedef struct packed {
        logic [1:0]   sel;
        logic [W-1:0] word;
        logic [W-1:0] exp_dac;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 12'hA5C, 12'hA5C},
        '{2'd1, 12'h3F0, 12'h3F0},
        '{2'd2, 12'hFFF, 12'hFFF},
        '{2'd3, 12'h000, 12'h000},
        '{2'd0, 12'h801, 12'h801},
        '{2'd1, 12'h5A5, 12'h5A5},
        '{2'd2, 12'h7FE, 12'h7FE},
        '{2'd3, 12'hC33, 12'hC33}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe_a = 1'b0, strobe_b = 1'b0, strobe_c = 1'b1, strobe_d = 1'b0;
    logic ser_in = 1'b0, xfer_a_n = 1'b1, xfer_b_n = 1'b1, zero_n = 1'b1;
    logic         ser_out;
    logic [W-1:0] dac_word;

    int total = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [W-1:0] model = '0;

    always #(CLK_P/2) clk = ~clk;

    serial_dac_loader dut (
        .clk(clk), .rst(rst),
        .strobe_a(strobe_a), .strobe_b(strobe_b),
        .strobe_c(strobe_c), .strobe_d(strobe_d),
        .ser_in(ser_in), .xfer_a_n(xfer_a_n), .xfer_b_n(xfer_b_n),
        .zero_n(zero_n), .ser_out(ser_out), .dac_word(dac_word)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_strobe(int sel, logic act);
        case (sel)
            0: strobe_a = act;
            1: strobe_b = act;
            2: strobe_c = ~act;
            default: strobe_d = act;
        endcase
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int sel, logic b);
        @(negedge clk) ser_in = b;
        wait_n(2);
        drive_strobe(sel, 1'b1);
        wait_n(3);
        drive_strobe(sel, 1'b0);
        wait_n(3);
        model = {model[W-2:0], b};
    endtask

    task automatic do_load();
        @(negedge clk);
        xfer_a_n = 1'b0;
        xfer_b_n = 1'b0;
        wait_n(4);
        xfer_a_n = 1'b1;
        xfer_b_n = 1'b1;
        wait_n(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] held;
        logic         so;
        // R1 reset state
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        check("R1 dac after reset", dac_word, '0);
        check("R1 ser_out after reset", {11'b0, ser_out}, '0);
        do_load();
        check("R1 register empty after reset", dac_word, '0);

        // Vector table: shift each word with one strobe, check cascade, load
        for (int v = 0; v < 8; v++) begin
            prev = model;
            for (int k = W - 1; k >= 0; k--) begin
                pulse(VECS[v].sel, VECS[v].word[k]);
                check("R8 cascade bit", {11'b0, ser_out}, {11'b0, prev[k]});
            end
            do_load();
            if (VECS[v].sel == 2'd2)
                check("R4 falling strobe word", dac_word, VECS[v].exp_dac);
            else
                check("R3 R2 rising strobe word", dac_word, VECS[v].exp_dac);
        end

        // R10 shifts without transfer leave the word
        for (int k = 0; k < 4; k++) pulse(0, k[0]);
        check("R10 hold across shifts", dac_word, 12'hC33);

        // R6 one enable alone does nothing
        @(negedge clk) xfer_a_n = 1'b0;
        wait_n(5);
        check("R6 only first enable", dac_word, 12'hC33);
        xfer_a_n = 1'b1;
        xfer_b_n = 1'b0;
        wait_n(5);
        check("R6 only second enable", dac_word, 12'hC33);
        xfer_b_n = 1'b1;
        wait_n(3);
        do_load();
        check("R6 both enables", dac_word, model);

        // R5 masked edges: b high shifts once, then a and c edges do nothing
        @(negedge clk) ser_in = 1'b1;
        wait_n(2);
        strobe_b = 1'b1;
        wait_n(3);
        model = {model[W-2:0], 1'b1};
        so = ser_out;
        ser_in = 1'b0;
        wait_n(2);
        strobe_a = 1'b1;  wait_n(3);
        strobe_a = 1'b0;  wait_n(3);
        strobe_c = 1'b0;  wait_n(3);
        strobe_c = 1'b1;  wait_n(3);
        strobe_b = 1'b0;  wait_n(3);
        check("R5 ser_out unchanged by masked edges", {11'b0, ser_out}, {11'b0, so});
        do_load();
        check("R5 masked edges add no bit", dac_word, model);

        // R4 c falling while a high gives no shift
        @(negedge clk) ser_in = 1'b1;
        wait_n(2);
        strobe_a = 1'b1;
        wait_n(3);
        model = {model[W-2:0], 1'b1};
        ser_in = 1'b0;
        wait_n(2);
        strobe_c = 1'b0;  wait_n(3);
        strobe_c = 1'b1;  wait_n(3);
        strobe_a = 1'b0;  wait_n(3);
        do_load();
        check("R4 gated falling strobe", dac_word, model);

        // R7 zero beats transfer and ignores strobes
        @(negedge clk);
        zero_n   = 1'b0;
        xfer_a_n = 1'b0;
        xfer_b_n = 1'b0;
        wait_n(4);
        check("R7 zero over transfer", dac_word, '0);
        pulse(3, 1'b1);
        check("R7 zero during strobes", dac_word, '0);
        zero_n = 1'b0;
        @(negedge clk) zero_n = 1'b1;
        wait_n(4);
        check("R7 transfer resumes after zero", dac_word, model);
        xfer_a_n = 1'b1;
        xfer_b_n = 1'b1;
        wait_n(3);

        // R9 one-cycle transfer together with the final shift
        held = 12'h9B7;
        for (int k = W - 1; k >= 1; k--) pulse(3, held[k]);
        @(negedge clk) ser_in = held[0];
        wait_n(2);
        strobe_d = 1'b1;
        xfer_a_n = 1'b0;
        xfer_b_n = 1'b0;
        @(negedge clk);
        xfer_a_n = 1'b1;
        xfer_b_n = 1'b1;
        wait_n(4);
        strobe_d = 1'b0;
        wait_n(3);
        model = {model[W-2:0], held[0]};
        check("R9 transfer with final shift", dac_word, 12'h9B7);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule